// File: doc/BRIEF.md
# Monochrome Glyph Triple Expander

This block turns a one-bit-per-pixel glyph bitmap into the host data stream that a 24-bit-per-pixel display engine needs when that engine runs in byte mode. In byte mode every pixel takes three byte positions. For this reason each bitmap bit is written out three times in a row. The repeated bits are packed into 32-bit words and sent on a valid/ready stream. The block is meant for monochrome images on a 24 bpp display only. Other depths skip it.

A start pulse captures the image width in pixels and the height in rows, and clears all internal state. Source bytes then arrive on a valid/ready byte stream. Each row is padded to a whole number of bytes. At the end of a row, the unused bits of the current source byte are thrown away, and the current output byte is closed early. After the last pixel, any partly filled word is sent with its unused bytes zeroed. A done flag rises once that word has been taken.

Top module: `glyph_triple_pack`

## Requirements
- R1: Each source pixel bit appears three times in a row in the output bit sequence. The next source bit follows only after the third copy.
- R2: Source bits are taken starting at bit 7 of each input byte. Output bits fill each output byte starting at its bit 7.
- R3: Output bytes are grouped four to a word in the order they are filled. The first byte goes in bits 7:0, the second in 15:8, the third in 23:16 and the fourth in 31:24.
- R4: When a row's last pixel has been expanded, the remaining bits of that source byte are discarded, and the next row begins with a fresh input byte. The open output byte is closed with its unwritten low bits at zero, so every row takes ceil(3*width/8) output bytes.
- R5: Exactly ceil(width/8)*height input bytes are accepted per image. After the last one, `in_ready` stays low.
- R6: The final word is sent even when partly filled, with its unfilled byte lanes at zero. No word follows it.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged.
- R8: A new input byte is accepted only after every pixel of the current byte has been used. In the cycle after an accept, `in_ready` is low.
- R9: `start` loads `cfg_width` and `cfg_height`, clears all state and lowers `done`. `done` rises in the cycle after the final word is accepted and stays high until the next `start`.
- R10: A start with zero width or zero height raises `done` in the next cycle. No input is accepted and no word is produced.
- R11: After reset, `in_ready`, `out_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that loads the geometry and begins an image |
| cfg_width | input | WIDTH_BITS | Image width in pixels |
| cfg_height | input | HEIGHT_BITS | Image height in rows |
| in_data | input | 8 | Source bitmap byte |
| in_valid | input | 1 | Source byte present |
| in_ready | output | 1 | Block can take a source byte |
| out_data | output | 8*WORD_BYTES | Packed host data word |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Consumer takes the output word |
| done | output | 1 | Image finished and last word taken |

## Verification
The bench builds the block with WIDTH_BITS=5 and HEIGHT_BITS=2. Because the counters are this small, it can try every width from 0 to 31 with every height from 0 to 3. That covers every possible offset of a row end inside a source byte, inside an output byte and inside a word. It also covers the zero-size starts and the largest counter values. Each geometry runs twice: once with both streams running freely, and once with gaps on the input side and stalls on the output side. The expected words come from a bit-level reference computed in the bench.

// File: rtl/gtp_pkg.sv
package gtp_pkg;
  localparam int unsigned SRC_BITS = 8;

  typedef enum logic [1:0] {
    WK_IDLE  = 2'd0,
    WK_RUN   = 2'd1,
    WK_DRAIN = 2'd2
  } walk_state_e;
endpackage

// File: rtl/gtp_bit_walker.sv
module gtp_bit_walker
  import gtp_pkg::*;
#(
  parameter int unsigned WIDTH_BITS  = 12,
  parameter int unsigned HEIGHT_BITS = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [WIDTH_BITS-1:0]  cfg_width,
  input  logic [HEIGHT_BITS-1:0] cfg_height,
  input  logic [SRC_BITS-1:0]    in_data,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic                   stall,
  input  logic                   final_taken,
  output logic                   emit,
  output logic                   emit_bit,
  output logic                   row_end,
  output logic                   last_pix,
  output logic                   done
);

  walk_state_e             state_q, state_d;
  logic [WIDTH_BITS-1:0]   width_q, width_d;
  logic [HEIGHT_BITS-1:0]  height_q, height_d;
  logic [SRC_BITS-1:0]     byte_q, byte_d;
  logic                    have_q, have_d;
  logic [2:0]              bidx_q, bidx_d;
  logic [1:0]              rep_q, rep_d;
  logic [WIDTH_BITS-1:0]   pix_q, pix_d;
  logic [HEIGHT_BITS-1:0]  row_q, row_d;
  logic                    done_q, done_d;

  logic take;
  logic third;
  logic pix_last;
  logic row_last;

  assign in_ready = (state_q == WK_RUN) && !have_q;
  assign take     = in_valid && in_ready;
  assign emit     = (state_q == WK_RUN) && have_q && !stall;
  assign emit_bit = byte_q[bidx_q];
  assign third    = (rep_q == 2'd2);
  assign pix_last = (pix_q == width_q - 1'b1);
  assign row_last = (row_q == height_q - 1'b1);
  assign row_end  = emit && third && pix_last;
  assign last_pix = row_end && row_last;
  assign done     = done_q;

  always_comb begin
    state_d  = state_q;
    width_d  = width_q;
    height_d = height_q;
    byte_d   = byte_q;
    have_d   = have_q;
    bidx_d   = bidx_q;
    rep_d    = rep_q;
    pix_d    = pix_q;
    row_d    = row_q;
    done_d   = done_q;
    if (start) begin
      width_d  = cfg_width;
      height_d = cfg_height;
      byte_d   = '0;
      have_d   = 1'b0;
      bidx_d   = 3'd7;
      rep_d    = 2'd0;
      pix_d    = '0;
      row_d    = '0;
      if ((cfg_width == '0) || (cfg_height == '0)) begin
        state_d = WK_IDLE;
        done_d  = 1'b1;
      end else begin
        state_d = WK_RUN;
        done_d  = 1'b0;
      end
    end else begin
      unique case (state_q)
        WK_RUN: begin
          if (take) begin
            byte_d = in_data;
            have_d = 1'b1;
            bidx_d = 3'd7;
            rep_d  = 2'd0;
          end
          if (emit) begin
            if (third) begin
              rep_d = 2'd0;
              if (pix_last) begin
                pix_d  = '0;
                have_d = 1'b0;
                row_d  = row_q + 1'b1;
                if (row_last) begin
                  state_d = WK_DRAIN;
                end
              end else begin
                pix_d = pix_q + 1'b1;
                if (bidx_q == 3'd0) begin
                  have_d = 1'b0;
                end else begin
                  bidx_d = bidx_q - 3'd1;
                end
              end
            end else begin
              rep_d = rep_q + 2'd1;
            end
          end
        end
        WK_DRAIN: begin
          if (final_taken) begin
            state_d = WK_IDLE;
            done_d  = 1'b1;
          end
        end
        default: begin
          state_d = WK_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= WK_IDLE;
      width_q  <= '0;
      height_q <= '0;
      byte_q   <= '0;
      have_q   <= 1'b0;
      bidx_q   <= 3'd7;
      rep_q    <= 2'd0;
      pix_q    <= '0;
      row_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      width_q  <= width_d;
      height_q <= height_d;
      byte_q   <= byte_d;
      have_q   <= have_d;
      bidx_q   <= bidx_d;
      rep_q    <= rep_d;
      pix_q    <= pix_d;
      row_q    <= row_d;
      done_q   <= done_d;
    end
  end

  AST_REP_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n) rep_q != 2'd3); // R1
  AST_SRC_STEP: assert property (@(posedge clk) disable iff (!rst_n) (emit && third && !pix_last && (bidx_q != 3'd0) && !start) |=> (bidx_q == $past(bidx_q) - 3'd1)); // R2
  AST_SRC_HELD: assert property (@(posedge clk) disable iff (!rst_n) (have_q && !emit && !start) |=> (have_q && $stable(byte_q))); // R8
  AST_DRAIN_CLOSED: assert property (@(posedge clk) disable iff (!rst_n) (state_q == WK_DRAIN) |-> !in_ready); // R5

endmodule

// File: rtl/gtp_word_packer.sv
module gtp_word_packer #(
  parameter int unsigned WORD_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    emit,
  input  logic                    emit_bit,
  input  logic                    row_end,
  input  logic                    last_pix,
  input  logic                    out_ready,
  output logic [8*WORD_BYTES-1:0] out_data,
  output logic                    out_valid,
  output logic                    final_taken
);

  localparam int unsigned WORD_W = 8 * WORD_BYTES;
  localparam int unsigned LANE_W = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1;
  localparam int unsigned POS_W  = LANE_W + 3;

  logic [WORD_W-1:0] word_q, word_d;
  logic [LANE_W-1:0] lane_q, lane_d;
  logic [2:0]        obit_q, obit_d;
  logic              valid_q, valid_d;
  logic              last_q, last_d;

  logic [POS_W-1:0]  bit_pos;
  logic [WORD_W-1:0] set_bit;
  logic              handshake;
  logic              lane_full;
  logic              close_byte;

  assign bit_pos     = {lane_q, ~obit_q};
  assign handshake   = valid_q && out_ready;
  assign lane_full   = (lane_q == LANE_W'(WORD_BYTES - 1));
  assign close_byte  = row_end || (obit_q == 3'd7);
  assign out_data    = word_q;
  assign out_valid   = valid_q;
  assign final_taken = handshake && last_q;

  for (genvar g = 0; g < WORD_W; g++) begin : g_pos
    assign set_bit[g] = emit && (bit_pos == POS_W'(g));
  end

  always_comb begin
    word_d  = word_q;
    lane_d  = lane_q;
    obit_d  = obit_q;
    valid_d = valid_q;
    last_d  = last_q;
    if (start || handshake) begin
      word_d  = '0;
      lane_d  = '0;
      obit_d  = 3'd0;
      valid_d = 1'b0;
      last_d  = 1'b0;
    end else if (emit) begin
      for (int j = 0; j < WORD_W; j++) begin
        if (set_bit[j]) begin
          word_d[j] = emit_bit;
        end
      end
      if (close_byte) begin
        obit_d = 3'd0;
        if (lane_full || last_pix) begin
          valid_d = 1'b1;
          last_d  = last_pix;
        end else begin
          lane_d = lane_q + 1'b1;
        end
      end else begin
        obit_d = obit_q + 3'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      lane_q  <= '0;
      obit_q  <= 3'd0;
      valid_q <= 1'b0;
      last_q  <= 1'b0;
    end else begin
      word_q  <= word_d;
      lane_q  <= lane_d;
      obit_q  <= obit_d;
      valid_q <= valid_d;
      last_q  <= last_d;
    end
  end

  AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n) (valid_q && !out_ready && !start) |=> (valid_q && $stable(word_q))); // R7
  AST_NO_FILL_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n) emit |-> !valid_q); // R7

endmodule

// File: rtl/glyph_triple_pack.sv
module glyph_triple_pack #(
  parameter int unsigned WIDTH_BITS  = 12,
  parameter int unsigned HEIGHT_BITS = 12,
  parameter int unsigned WORD_BYTES  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [WIDTH_BITS-1:0]   cfg_width,
  input  logic [HEIGHT_BITS-1:0]  cfg_height,
  input  logic [7:0]              in_data,
  input  logic                    in_valid,
  output logic                    in_ready,
  output logic [8*WORD_BYTES-1:0] out_data,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic                    done
);

  logic emit;
  logic emit_bit;
  logic row_end;
  logic last_pix;
  logic final_taken;

  gtp_bit_walker #(
    .WIDTH_BITS  (WIDTH_BITS),
    .HEIGHT_BITS (HEIGHT_BITS)
  ) u_walker (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .cfg_width   (cfg_width),
    .cfg_height  (cfg_height),
    .in_data     (in_data),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .stall       (out_valid),
    .final_taken (final_taken),
    .emit        (emit),
    .emit_bit    (emit_bit),
    .row_end     (row_end),
    .last_pix    (last_pix),
    .done        (done)
  );

  gtp_word_packer #(
    .WORD_BYTES (WORD_BYTES)
  ) u_packer (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .emit        (emit),
    .emit_bit    (emit_bit),
    .row_end     (row_end),
    .last_pix    (last_pix),
    .out_ready   (out_ready),
    .out_data    (out_data),
    .out_valid   (out_valid),
    .final_taken (final_taken)
  );

  AST_DONE_ON_FINAL: assert property (@(posedge clk) disable iff (!rst_n) (final_taken && !start) |=> done); // R9
  AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n) done |-> (!in_ready && !out_valid)); // R10

endmodule

// File: tb/glyph_triple_pack_test.sv
module glyph_triple_pack_test;

  localparam int WB = 5;
  localparam int HB = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic [WB-1:0] cfg_width;
  logic [HB-1:0] cfg_height;
  logic [7:0]    in_data;
  logic          in_valid;
  logic          in_ready;
  logic [31:0]   out_data;
  logic          out_valid;
  logic          out_ready;
  logic          done;

  int total = 0;
  int bad   = 0;
  int sent  = 0;
  int n_in  = 0;
  int n_words = 0;
  logic [7:0] exp_b [0:63];

  always #10 clk = ~clk;

  glyph_triple_pack #(.WIDTH_BITS(WB), .HEIGHT_BITS(HB), .WORD_BYTES(4)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_width(cfg_width), .cfg_height(cfg_height),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready), .done(done)
  );

  function automatic logic [7:0] din(int idx, int w, int h);
    return 8'((idx * 37 + w * 11 + h * 5 + 90) ^ (idx * 8));
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, expv);
    end
  endtask

  task automatic build_exp(input int w, input int h);
    int bpr;
    int nb;
    bpr = (w + 7) / 8;
    nb  = 0;
    for (int i = 0; i < 64; i++) exp_b[i] = 8'h00;
    for (int r = 0; r < h; r++) begin
      logic [7:0] cur;
      int ob;
      cur = 8'h00;
      ob  = 0;
      for (int p = 0; p < w; p++) begin
        logic [7:0] sb;
        logic b;
        sb = din(r * bpr + p / 8, w, h);
        b  = sb[7 - (p % 8)];
        for (int k = 0; k < 3; k++) begin
          cur[7 - ob] = b;
          ob++;
          if (ob == 8) begin
            exp_b[nb] = cur;
            nb++;
            cur = 8'h00;
            ob  = 0;
          end
        end
      end
      if (ob != 0) begin
        exp_b[nb] = cur;
        nb++;
      end
    end
    n_in    = bpr * h;
    n_words = (nb + 3) / 4;
  endtask

  task automatic drive_in(input int w, input int h, input int mode);
    int cyc;
    bit took;
    cyc  = 0;
    took = 1'b0;
    while (sent < n_in) begin
      in_valid = (mode == 0) || ((cyc % 3) != 1);
      in_data  = din(sent, w, h);
      #1;
      if (took) chk(!in_ready, "R8", "in_ready after accept", {31'd0, in_ready}, 32'd0);
      took = 1'b0;
      if (in_valid && in_ready) begin
        sent++;
        took = 1'b1;
      end
      @(negedge clk);
      cyc++;
    end
    in_valid = 1'b0;
  endtask

  task automatic watch_out(input int mode);
    int got;
    int c;
    bit hold;
    bit all_sent;
    logic [31:0] hold_d;
    got = 0;
    c = 0;
    hold = 1'b0;
    all_sent = 1'b0;
    hold_d = '0;
    while (got < n_words) begin
      out_ready = (mode == 0) || ((c % 4) != 2);
      #2;
      if (hold) chk(out_valid && (out_data == hold_d), "R7", "stalled word", out_data, hold_d);
      hold = 1'b0;
      if (all_sent && in_ready) chk(1'b0, "R5", "in_ready after last byte", 32'd1, 32'd0);
      if (out_valid) begin
        if (out_ready) begin
          logic [31:0] ew;
          ew = {exp_b[4*got+3], exp_b[4*got+2], exp_b[4*got+1], exp_b[4*got]};
          if (got == n_words - 1)
            chk(out_data == ew, "R6 R4 R3", "final word", out_data, ew);
          else
            chk(out_data == ew, "R1 R2 R3 R4", "word", out_data, ew);
          got++;
        end else begin
          hold   = 1'b1;
          hold_d = out_data;
        end
      end
      all_sent = (sent == n_in);
      @(negedge clk);
      c++;
    end
    out_ready = 1'b0;
    #2;
    chk(done == 1'b1, "R9", "done after final word", {31'd0, done}, 32'd1);
    chk(out_valid == 1'b0, "R6", "no extra word", {31'd0, out_valid}, 32'd0);
    chk(sent == n_in, "R5", "input byte count", sent, n_in);
    chk(in_ready == 1'b0, "R5", "in_ready after image", {31'd0, in_ready}, 32'd0);
  endtask

  task automatic run_case(input int w, input int h, input int mode);
    build_exp(w, h);
    sent = 0;
    @(negedge clk);
    cfg_width  = WB'(w);
    cfg_height = HB'(h);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    #1;
    if (w == 0 || h == 0) begin
      chk(done == 1'b1, "R10", "done on empty image", {31'd0, done}, 32'd1);
      for (int i = 0; i < 3; i++) begin
        in_valid = 1'b1;
        out_ready = 1'b1;
        chk(!in_ready && !out_valid, "R10", "idle on empty image", {30'd0, in_ready, out_valid}, 32'd0);
        @(negedge clk);
        #1;
      end
      in_valid = 1'b0;
      out_ready = 1'b0;
    end else begin
      chk(done == 1'b0, "R9", "done cleared by start", {31'd0, done}, 32'd0);
      fork
        drive_in(w, h, mode);
        watch_out(mode);
      join
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R9 watchdog expired act=%h exp=%h", 32'd0, 32'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n      = 1'b0;
    start      = 1'b0;
    cfg_width  = '0;
    cfg_height = '0;
    in_data    = '0;
    in_valid   = 1'b0;
    out_ready  = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(!in_ready && !out_valid && !done, "R11", "reset state",
        {29'd0, in_ready, out_valid, done}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int mode = 0; mode < 2; mode++) begin
      for (int h = 0; h < 4; h++) begin
        for (int w = 0; w < 32; w++) begin
          run_case(w, h, mode);
        end
      end
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule